// File: doc/BRIEF.md
# Segmented Virtual Address Expander

This block widens a 32-bit effective address produced by a processor into a 40-bit virtual address. The top four address bits are not passed on. They index a file of sixteen writable 12-bit segment identifier registers. The chosen identifier is placed above the 28 untouched low-order bits, giving 4,096 possible segments of 256 MB each.

Software loads the identifiers through a simple write port made of an enable, an index and an identifier value. The translation path takes an address with a valid flag. By default it returns the widened address one clock later with a matching valid flag. A parameter selects a purely combinational output instead. A write that targets the segment being translated in the same cycle is forwarded, so the translation already sees the new identifier.

Top module: `segva_expander`

## Requirements
- R1: `va_addr[27:0]` equals `ea_addr[27:0]` of the address accepted on the previous clock edge.
- R2: `va_addr[39:28]` equals the identifier held in the register whose index is `ea_addr[31:28]` (index 0 to 15), giving a 40-bit output.
- R3: The block holds sixteen independent registers. A write to one index leaves the other fifteen unchanged.
- R4: A write with `wr_en`=1 stores `wr_sid` at `wr_idx`, and later translations see it from the next edge onward. A translation in the same cycle to the same index gets the new `wr_sid`. A translation to a different index in that cycle is unaffected.
- R5: Reset clears all sixteen identifiers to zero and drives `va_valid`=0 and `va_addr`=0.
- R6: `va_valid` equals the `ea_valid` of the previous edge, so the registered output has one cycle of latency.
- R7: While `ea_valid`=0, `va_addr` keeps its previous value.
- R8: While `wr_en`=0, the values on `wr_idx` and `wr_sid` change no identifier and are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Identifier register write enable |
| wr_idx | input | 4 | Register index to write |
| wr_sid | input | 12 | Segment identifier to store |
| ea_valid | input | 1 | Effective address is valid |
| ea_addr | input | 32 | Effective address |
| va_valid | output | 1 | Virtual address is valid |
| va_addr | output | 40 | Virtual address: identifier in [39:28], offset in [27:0] |

## Verification
Translations are run against indices 0, 5 and 15, with offsets of all zeros, all ones and mixed bits. This tells whether the offset is copied unchanged and whether the index picks the right register. Some writes hit the index being translated in the same cycle and others miss it, which separates the forwarding path from a plain registered read. Writes with the enable low, and cycles with the valid flag low, show that ignored inputs leave the identifiers and the held output untouched. After a reset in the middle of a run, a sweep writes and then reads back all sixteen registers with distinct values, which exposes aliasing between indices and registers that fail to clear.

// File: rtl/segva_pkg.sv
package segva_pkg;
  localparam int unsigned SEGVA_EA_W  = 32;
  localparam int unsigned SEGVA_IDX_W = 4;
  localparam int unsigned SEGVA_SID_W = 12;
endpackage

// File: rtl/segva_rst_sync.sv
module segva_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/segva_sid_file.sv
module segva_sid_file #(
  parameter int unsigned IDX_W = segva_pkg::SEGVA_IDX_W,
  parameter int unsigned SID_W = segva_pkg::SEGVA_SID_W,
  localparam int unsigned NSEG = 1 << IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [SID_W-1:0]           wr_sid,
  output logic [NSEG-1:0][SID_W-1:0] sid_q
);
  logic [NSEG-1:0] we_vec;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_comb we_vec[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sid_q[g] <= '0;
      else if (we_vec[g])  sid_q[g] <= wr_sid;
    end
  end

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!armed_q)
    wr_en |=> sid_q[$past(wr_idx)] == $past(wr_sid)); // R4

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!armed_q)
    !wr_en |=> $stable(sid_q)); // R8
endmodule

// File: rtl/segva_sid_select.sv
module segva_sid_select #(
  parameter int unsigned IDX_W  = segva_pkg::SEGVA_IDX_W,
  parameter int unsigned SID_W  = segva_pkg::SEGVA_SID_W,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned NSEG  = 1 << IDX_W
) (
  input  logic [NSEG-1:0][SID_W-1:0] sid_q,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [SID_W-1:0]           wr_sid,
  output logic [SID_W-1:0]           sid_out
);
  logic [SID_W-1:0] stored;
  always_comb stored = sid_q[rd_idx];

  if (BYPASS) begin : g_fwd
    always_comb sid_out = (wr_en && (wr_idx == rd_idx)) ? wr_sid : stored;
  end else begin : g_nofwd
    always_comb sid_out = stored;
  end
endmodule

// File: rtl/segva_out_stage.sv
module segva_out_stage #(
  parameter int unsigned VA_W    = 40,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VA_W-1:0] in_addr,
  output logic            out_valid,
  output logic [VA_W-1:0] out_addr
);
  if (OUT_REG) begin : g_reg
    logic            valid_d, valid_q;
    logic [VA_W-1:0] addr_d,  addr_q;
    logic            addr_en;

    always_comb begin
      valid_d = in_valid;
      addr_en = in_valid;
      addr_d  = in_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        addr_q  <= '0;
      end else begin
        valid_q <= valid_d;
        if (addr_en) addr_q <= addr_d;
      end
    end

    assign out_valid = valid_q;
    assign out_addr  = addr_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_addr  = in_addr;
  end
endmodule

// File: rtl/segva_expander.sv
module segva_expander #(
  parameter int unsigned EA_W    = segva_pkg::SEGVA_EA_W,
  parameter int unsigned IDX_W   = segva_pkg::SEGVA_IDX_W,
  parameter int unsigned SID_W   = segva_pkg::SEGVA_SID_W,
  parameter bit          OUT_REG = 1'b1,
  parameter bit          BYPASS  = 1'b1,
  localparam int unsigned OFS_W  = EA_W - IDX_W,
  localparam int unsigned VA_W   = SID_W + OFS_W,
  localparam int unsigned NSEG   = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SID_W-1:0] wr_sid,
  input  logic             ea_valid,
  input  logic [EA_W-1:0]  ea_addr,
  output logic             va_valid,
  output logic [VA_W-1:0]  va_addr
);
  logic                       rst_n_int;
  logic [NSEG-1:0][SID_W-1:0] sid_q;
  logic [SID_W-1:0]           sid_sel;
  logic [IDX_W-1:0]           seg_idx;
  logic [OFS_W-1:0]           seg_ofs;
  logic [VA_W-1:0]            va_next;

  always_comb begin
    seg_idx = ea_addr[EA_W-1 -: IDX_W];
    seg_ofs = ea_addr[OFS_W-1:0];
    va_next = {sid_sel, seg_ofs};
  end

  segva_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  segva_sid_file #(.IDX_W(IDX_W), .SID_W(SID_W)) u_file (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_sid (wr_sid),
    .sid_q  (sid_q)
  );

  segva_sid_select #(.IDX_W(IDX_W), .SID_W(SID_W), .BYPASS(BYPASS)) u_sel (
    .sid_q   (sid_q),
    .rd_idx  (seg_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_sid  (wr_sid),
    .sid_out (sid_sel)
  );

  segva_out_stage #(.VA_W(VA_W), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (ea_valid),
    .in_addr   (va_next),
    .out_valid (va_valid),
    .out_addr  (va_addr)
  );

  if (OUT_REG) begin : g_chk
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int) armed_q <= 1'b0;
      else            armed_q <= 1'b1;
    end

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!armed_q)
      ea_valid |=> va_addr[OFS_W-1:0] == $past(ea_addr[OFS_W-1:0])); // R1

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!armed_q)
      ea_valid |=> va_valid); // R6

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!armed_q)
      !ea_valid |=> !va_valid); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!armed_q)
      !ea_valid |=> $stable(va_addr)); // R7

    if (BYPASS) begin : g_fwd_chk
      AST_FORWARD_NEW: assert property (@(posedge clk) disable iff (!armed_q)
        (ea_valid && wr_en && (wr_idx == ea_addr[EA_W-1 -: IDX_W]))
        |=> va_addr[VA_W-1 -: SID_W] == $past(wr_sid)); // R4
    end
  end
endmodule

// File: tb/segva_expander_tb.sv
module segva_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [11:0] wr_sid;
  logic        ea_valid;
  logic [31:0] ea_addr;
  logic        va_valid;
  logic [39:0] va_addr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  segva_expander u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sid(wr_sid),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .va_valid(va_valid), .va_addr(va_addr)
  );

  function automatic logic [90:0] mk(input logic we, input logic [3:0] wi,
      input logic [11:0] ws, input logic v, input logic [31:0] ea,
      input logic ev, input logic [39:0] eva);
    return {we, wi, ws, v, ea, ev, eva};
  endfunction

  localparam int NROW = 14;
  localparam logic [90:0] VEC [NROW] = '{
    mk(1'b1, 4'h3, 12'hABC, 1'b0, 32'h0000_0000, 1'b0, 40'h000_0000000),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'h3123_4567, 1'b1, 40'hABC_1234567),
    mk(1'b1, 4'h0, 12'h001, 1'b1, 32'h0FFF_FFFF, 1'b1, 40'h001_FFFFFFF),
    mk(1'b1, 4'hF, 12'hFFF, 1'b1, 32'hF000_0000, 1'b1, 40'hFFF_0000000),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'h5ABC_DEF0, 1'b1, 40'h000_ABCDEF0),
    mk(1'b0, 4'h5, 12'h777, 1'b1, 32'h5000_0001, 1'b1, 40'h000_0000001),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'h5000_0002, 1'b1, 40'h000_0000002),
    mk(1'b0, 4'h0, 12'h000, 1'b0, 32'h3FFF_FFFF, 1'b0, 40'h000_0000002),
    mk(1'b1, 4'h3, 12'h456, 1'b1, 32'h4000_0010, 1'b1, 40'h000_0000010),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'h3000_0020, 1'b1, 40'h456_0000020),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'h0000_0030, 1'b1, 40'h001_0000030),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'hFFFF_FFFF, 1'b1, 40'hFFF_FFFFFFF),
    mk(1'b1, 4'h3, 12'h999, 1'b0, 32'h3000_0000, 1'b0, 40'hFFF_FFFFFFF),
    mk(1'b0, 4'h0, 12'h000, 1'b1, 32'h3000_0000, 1'b1, 40'h999_0000000)
  };
  localparam string TAG [NROW] = '{
    "R6", "R2", "R4", "R4", "R5", "R8", "R8",
    "R7", "R4", "R4", "R3", "R1", "R7", "R4"
  };

  task automatic chk(input string tag, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] wi, input logic [11:0] ws,
                       input logic v, input logic [31:0] ea);
    wr_en = we; wr_idx = wi; wr_sid = ws; ea_valid = v; ea_addr = ea;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_sid = '0; ea_valid = 1'b0; ea_addr = '0;
    repeat (3) @(negedge clk);
    chk("R5", "valid in reset", 40'(va_valid), 40'h0);
    chk("R5", "addr in reset", va_addr, 40'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    chk("R5", "valid after release", 40'(va_valid), 40'h0);
    chk("R5", "addr after release", va_addr, 40'h0);

    for (int i = 0; i < NROW; i++) begin
      logic [90:0] r;
      r = VEC[i];
      drive(r[90], r[89:86], r[85:74], r[73], r[72:41]);
      chk(TAG[i], $sformatf("row %0d valid", i), 40'(va_valid), 40'(r[40]));
      chk(TAG[i], $sformatf("row %0d addr", i), va_addr, r[39:0]);
    end

    // R5: reset mid-run clears the identifiers written above
    do_reset();
    drive(1'b0, 4'h0, 12'h0, 1'b1, 32'hF123_4567);
    chk("R5", "idx15 cleared", va_addr, 40'h000_1234567);
    drive(1'b0, 4'h0, 12'h0, 1'b1, 32'h3000_0001);
    chk("R5", "idx3 cleared", va_addr, 40'h000_0000001);

    // R3: distinct values in all sixteen registers, then read back
    for (int i = 0; i < 16; i++)
      drive(1'b1, 4'(i), 12'((i * 37 + 5) & 12'hFFF), 1'b0, 32'h0);
    for (int i = 0; i < 16; i++) begin
      drive(1'b0, 4'h0, 12'h0, 1'b1, {4'(i), 28'h000_0ABC});
      chk("R3", $sformatf("sweep idx %0d", i), va_addr,
          {12'((i * 37 + 5) & 12'hFFF), 28'h000_0ABC});
    end

    // R6: valid drops one cycle after input valid drops
    drive(1'b0, 4'h0, 12'h0, 1'b0, 32'h0);
    chk("R6", "valid low after drop", 40'(va_valid), 40'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule